// File: doc/BRIEF.md
# PLL Lock Timer and Clock-Source Sequencer

This block governs when a phase-locked loop is switched on, when the chip's clock may move onto the PLL output, and when the PLL may be switched off again. Software sees two 8-bit registers. A control register holds a PLL-enable bit, a PLL-select bit and a read-only lock flag. A timing register holds a 2-bit code that sets the lockup interval. When the PLL is enabled, a counter clocked by the oscillator counts a power-of-two number of cycles and then reports lock. The select output that drives the downstream glitch-free clock mux is forced to the oscillator path until lock is reported.

The block also enforces the safe order for leaving the PLL. The select bit must be cleared first, and the enable may be dropped only after a settling window. A low-power mode input stops the PLL automatically in the deep idle and stop modes. The light idle mode leaves the PLL alone. On the return to run mode the PLL comes back with a fresh lockup count if it was enabled before entry.

Top module: `pll_lock_sequencer`

## Requirements
- R1: After reset the enable bit is 1, the select bit is 0, the lock flag is 0 and the lockup code is 3. Reads return 0x01 at address 0 and 0x03 at address 1.
- R2: `locked` rises exactly 2^(10+code) clock edges after `pll_en` goes high, counting the first edge with `pll_en` high as edge 1.
- R3: `locked` is 0 in every cycle in which `pll_en` is 0. The flag drops in the same cycle as the enable.
- R4: A write to address 1 is ignored while a lockup count is running, that is while `pll_en` is 1 and `locked` is 0.
- R5: `clk_sel_pll` is 1 only when the select bit is 1 and `locked` is 1. The output never moves to the PLL before lock.
- R6: A write to address 0 that clears bit 0 (enable) takes effect only when both hold: that write and the stored value have bit 1 (select) at 0, and at least 8 clock edges have passed since the write that cleared the select bit. Otherwise the enable bit stays at 1 and the select bit takes the written value.
- R7: With `lp_mode` 2 (deep idle) or 3 (stop), `pll_en`, `locked` and `clk_sel_pll` are 0 in the same cycle, whatever the register contents. All register writes are ignored in these modes.
- R8: On return from mode 2 or 3, the enable and select bits hold their values from before entry. If the PLL was enabled, a full new lockup count runs before `locked` and then `clk_sel_pll` return.
- R9: `lp_mode` 1 (light idle) has no effect on `pll_en`, `locked` or `clk_sel_pll`.
- R10: Address 0 reads bit 0 as the enable bit, bit 1 as the select bit, bit 2 as the lock flag, and bits 7:3 as 0. Address 1 reads the code in bits 1:0 and 0 in bits 7:2. Writes to bits 7:2 of address 1 have no effect.
- R11: Once locked, the flag holds while `pll_en` stays 1. A code write accepted after lock does not disturb the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 control, 1 lockup code |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address: 0 control, 1 lockup code |
| rd_data | output | 8 | Read data, combinational |
| lp_mode | input | 2 | 0 run, 1 light idle, 2 deep idle, 3 stop |
| pll_en | output | 1 | Enable to the PLL |
| locked | output | 1 | Lock flag |
| clk_sel_pll | output | 1 | Clock mux select: 1 picks the PLL output |

## Verification
The lockup counter is run from three starts: the enable set by software, the automatic restart on leaving deep idle, and the start right after reset. The cycle just before and the cycle of lock are sampled, which separates an off-by-one count from a correct one. The stop guard is tried with the select still set, then with too few settling cycles, then with exactly the minimum. This separates a missing order check from a wrong window length. A long pseudo-random stretch mixes writes, reads and mode changes, including code writes made during a count. Every cycle of it is compared against a behavioural model.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

    typedef enum logic [1:0] {
        LP_RUN   = 2'd0,
        LP_LIGHT = 2'd1,
        LP_DEEP  = 2'd2,
        LP_STOP  = 2'd3
    } lp_mode_e;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_TIME = 1'b1;

    localparam logic [1:0] CODE_RESET = 2'd3;

    typedef struct packed {
        logic sel;
        logic on;
    } ctrl_t;

    typedef struct packed {
        logic       wr;
        logic       addr;
        logic [7:0] data;
    } bus_wr_t;

    // Deep idle and stop both have the upper mode bit set.
    function automatic logic is_deep(input logic [1:0] mode);
        return mode[1];
    endfunction

    // Number of oscillator cycles for a given lockup code.
    function automatic int unsigned lock_term(input int unsigned base_exp,
                                              input logic [1:0] code);
        return 32'd1 << (base_exp + 32'(code));
    endfunction

endpackage

// File: rtl/pllseq_regs.sv
module pllseq_regs
    import pllseq_pkg::*;
#(
    parameter int SETTLE  = 8,
    localparam int GUARD_W = $clog2(SETTLE + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_wr_t    bus,
    input  logic       deep,
    input  logic       counting,
    output ctrl_t      ctrl_q,
    output logic [1:0] code_q
);

    logic [GUARD_W-1:0] guard_q, guard_d;
    ctrl_t              ctrl_d;
    logic               ctrl_wr, time_wr, stop_ok;
    logic [1:0]         code_d;
    logic               unused_hi;

    assign unused_hi = ^bus.data[7:2];

    always_comb begin
        ctrl_wr = bus.wr && !deep && (bus.addr == ADDR_CTRL);
        time_wr = bus.wr && !deep && (bus.addr == ADDR_TIME) && !counting;
        stop_ok = !bus.data[1] && !ctrl_q.sel && (guard_q == GUARD_W'(SETTLE));

        ctrl_d = ctrl_q;
        if (ctrl_wr) begin
            ctrl_d.sel = bus.data[1];
            ctrl_d.on  = bus.data[0] | (ctrl_q.on & !stop_ok);
        end

        code_d = time_wr ? bus.data[1:0] : code_q;

        if (ctrl_d.sel)
            guard_d = '0;
        else if (ctrl_q.sel)
            guard_d = GUARD_W'(1);
        else if (guard_q != GUARD_W'(SETTLE))
            guard_d = guard_q + GUARD_W'(1);
        else
            guard_d = guard_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '{sel: 1'b0, on: 1'b1};
            code_q  <= CODE_RESET;
            guard_q <= GUARD_W'(SETTLE);
        end else begin
            ctrl_q  <= ctrl_d;
            code_q  <= code_d;
            guard_q <= guard_d;
        end
    end

endmodule

// File: rtl/pllseq_lock_timer.sv
module pllseq_lock_timer
    import pllseq_pkg::*;
#(
    parameter int CNT_W    = 14,
    parameter int BASE_EXP = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [1:0] code,
    output logic       lock_q,
    output logic       counting
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] term_m1;

    assign term_m1  = CNT_W'(lock_term(BASE_EXP, code) - 32'd1);
    assign counting = en && !lock_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q  <= '0;
            lock_q <= 1'b0;
        end else if (!lock_q) begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q == term_m1)
                lock_q <= 1'b1;
        end
    end

endmodule

// File: rtl/pllseq_readback.sv
module pllseq_readback
    import pllseq_pkg::*;
(
    input  logic       addr,
    input  ctrl_t      ctrl,
    input  logic       locked,
    input  logic [1:0] code,
    output logic [7:0] data
);

    always_comb begin
        if (addr == ADDR_TIME)
            data = {6'b0, code};
        else
            data = {5'b0, locked, ctrl.sel, ctrl.on};
    end

endmodule

// File: rtl/pll_lock_sequencer.sv
module pll_lock_sequencer
    import pllseq_pkg::*;
#(
    parameter int CNT_W    = 14,
    parameter int BASE_EXP = 10,
    parameter int SETTLE   = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [7:0] wr_data,
    input  logic       rd_addr,
    output logic [7:0] rd_data,
    input  logic [1:0] lp_mode,
    output logic       pll_en,
    output logic       locked,
    output logic       clk_sel_pll
);

    bus_wr_t    bus;
    ctrl_t      ctrl_q;
    logic [1:0] code_bit;
    logic       sel_bit;
    logic       deep, lock_q, counting;

    assign bus         = '{wr: wr_en, addr: wr_addr, data: wr_data};
    assign deep        = is_deep(lp_mode);
    assign sel_bit     = ctrl_q.sel;
    assign pll_en      = ctrl_q.on && !deep;
    assign locked      = lock_q && pll_en;
    assign clk_sel_pll = sel_bit && locked;

    pllseq_regs #(.SETTLE(SETTLE)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus      (bus),
        .deep     (deep),
        .counting (counting),
        .ctrl_q   (ctrl_q),
        .code_q   (code_bit)
    );

    pllseq_lock_timer #(.CNT_W(CNT_W), .BASE_EXP(BASE_EXP)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .en       (pll_en),
        .code     (code_bit),
        .lock_q   (lock_q),
        .counting (counting)
    );

    pllseq_readback u_rd (
        .addr   (rd_addr),
        .ctrl   (ctrl_q),
        .locked (locked),
        .code   (code_bit),
        .data   (rd_data)
    );

endmodule

// File: rtl/pllseq_chk.sv
module pllseq_chk
    import pllseq_pkg::*;
#(
    parameter int SETTLE   = 8,
    parameter int BASE_EXP = 10
) (
    input logic       clk,
    input logic       rst,
    input logic [1:0] lp_mode,
    input logic       pll_en,
    input logic       locked,
    input logic       clk_sel_pll,
    input logic       sel_bit,
    input logic [1:0] code_bit
);

    logic [7:0]  age_q;
    logic [15:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            age_q <= 8'(SETTLE);
            run_q <= '0;
        end else begin
            if (sel_bit)
                age_q <= '0;
            else if (age_q < 8'(SETTLE))
                age_q <= age_q + 8'd1;
            if (!pll_en)
                run_q <= '0;
            else if (run_q != 16'hFFFF)
                run_q <= run_q + 16'd1;
        end
    end

    // R2
    a_r2_lock_after_term: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> (32'(run_q) == lock_term(BASE_EXP, code_bit)));

    // R3
    a_r3_lock_needs_en: assert property (@(posedge clk) disable iff (rst)
        !pll_en |-> !locked);

    // R4
    a_r4_code_frozen: assert property (@(posedge clk) disable iff (rst)
        (pll_en && !locked) |=> $stable(code_bit));

    // R5
    a_r5_sel_after_lock: assert property (@(posedge clk) disable iff (rst)
        clk_sel_pll |-> locked);

    // R6
    a_r6_stop_settled: assert property (@(posedge clk) disable iff (rst)
        ($fell(pll_en) && !lp_mode[1]) |-> (!sel_bit && age_q >= 8'(SETTLE)));

    // R7
    a_r7_deep_off: assert property (@(posedge clk) disable iff (rst)
        lp_mode[1] |-> (!pll_en && !locked && !clk_sel_pll));

endmodule

bind pll_lock_sequencer pllseq_chk #(.SETTLE(SETTLE), .BASE_EXP(BASE_EXP)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .lp_mode     (lp_mode),
    .pll_en      (pll_en),
    .locked      (locked),
    .clk_sel_pll (clk_sel_pll),
    .sel_bit     (sel_bit),
    .code_bit    (code_bit)
);

// File: tb/tb_pll_lock_sequencer.sv
module tb_pll_lock_sequencer;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en, wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data;
    logic [1:0] lp_mode;
    logic       pll_en, locked, clk_sel_pll;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // behavioural reference state
    int m_on, m_sel, m_code, m_lock, m_cnt, m_age;

    always #5 clk = ~clk;

    pll_lock_sequencer dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .lp_mode(lp_mode),
        .pll_en(pll_en), .locked(locked), .clk_sel_pll(clk_sel_pll)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin : model
        int deep, en, cnting, nsel, non, term;
        if (rst) begin
            m_on = 1; m_sel = 0; m_code = 3; m_lock = 0; m_cnt = 0; m_age = 8;
        end else begin
            deep   = (lp_mode >= 2) ? 1 : 0;
            en     = (m_on != 0 && deep == 0) ? 1 : 0;
            cnting = (en != 0 && m_lock == 0) ? 1 : 0;
            term   = 1 << (10 + m_code);
            nsel   = m_sel;
            non    = m_on;
            if (wr_en && deep == 0 && wr_addr == 1'b0) begin
                nsel = wr_data[1];
                if (wr_data[0]) non = 1;
                else if (m_on != 0 && (wr_data[1] || m_sel != 0 || m_age < 8)) non = 1;
                else non = 0;
            end
            if (wr_en && deep == 0 && wr_addr == 1'b1 && cnting == 0)
                m_code = wr_data[1:0];
            if (en == 0) begin
                m_cnt = 0; m_lock = 0;
            end else if (m_lock == 0) begin
                m_cnt++;
                if (m_cnt == term) m_lock = 1;
            end
            if (nsel != 0) m_age = 0;
            else if (m_sel != 0) m_age = 1;
            else if (m_age < 8) m_age++;
            m_sel = nsel;
            m_on  = non;
        end
    end

    always @(negedge clk) begin
        int e_en, e_lock, e_sel, e_rd;
        if (!rst && !done) begin
            e_en   = (m_on != 0 && lp_mode < 2) ? 1 : 0;
            e_lock = (m_lock != 0 && e_en != 0) ? 1 : 0;
            e_sel  = (m_sel != 0 && e_lock != 0) ? 1 : 0;
            e_rd   = rd_addr ? m_code : (e_lock * 4 + m_sel * 2 + m_on);
            check("R7 pll_en", pll_en, e_en);
            check("R2 locked", locked, e_lock);
            check("R5 clk_sel_pll", clk_sel_pll, e_sel);
            check("R10 rd_data", rd_data, e_rd);
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #5_000_000;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired, run did not finish");
            summary();
            $finish;
        end
    end

    initial begin
        int unsigned r;
        rst = 1'b1; wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0; rd_addr = 1'b0; lp_mode = 2'd0;
        tick(3);
        rst = 1'b0;
        #1;
        // R1 reset state
        rd_addr = 1'b0; #1 check("R1 ctrl read", rd_data, 8'h01);
        rd_addr = 1'b1; #1 check("R1 code read", rd_data, 8'h03);
        check("R1 locked", locked, 0);
        check("R1 clk_sel_pll", clk_sel_pll, 0);

        // R4 code write during the reset-started count is dropped
        wr(1'b1, 8'h00);
        check("R4 code held", rd_data, 8'h03);

        // R6 stop right after reset is allowed (select never set)
        wr(1'b0, 8'h00);
        check("R6 stop from reset", pll_en, 0);
        check("R3 lock clear", locked, 0);

        // R10 upper bits of the code register are ignored
        wr(1'b1, 8'hFC);
        check("R10 code upper bits", rd_data, 8'h00);

        // R2/R5 enable and select together, lock after 1024
        wr(1'b0, 8'h03);
        check("R5 no select before lock", clk_sel_pll, 0);
        tick(1023);
        check("R2 not yet locked", locked, 0);
        tick(1);
        check("R2 locked at term", locked, 1);
        check("R5 select after lock", clk_sel_pll, 1);

        // R11 code change after lock keeps the flag
        wr(1'b1, 8'h03);
        tick(5);
        check("R11 lock held", locked, 1);
        check("R11 code accepted", rd_data, 8'h03);

        // R6 ordering and settle window
        wr(1'b0, 8'h02);
        check("R6 stop with select refused", pll_en, 1);
        wr(1'b0, 8'h01);
        tick(2);
        wr(1'b0, 8'h00);
        check("R6 stop at 3 refused", pll_en, 1);
        tick(3);
        wr(1'b0, 8'h00);
        check("R6 stop at 7 refused", pll_en, 1);
        wr(1'b0, 8'h00);
        check("R6 stop at 8 accepted", pll_en, 0);

        // relock with code 0
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h03);
        tick(1024);
        check("R2 relock", locked, 1);

        // R9 light idle
        lp_mode = 2'd1;
        tick(20);
        check("R9 pll_en", pll_en, 1);
        check("R9 locked", locked, 1);
        check("R9 clk_sel_pll", clk_sel_pll, 1);

        // R7 deep idle
        lp_mode = 2'd2;
        #1;
        check("R7 pll_en off", pll_en, 0);
        check("R7 locked off", locked, 0);
        check("R7 select off", clk_sel_pll, 0);
        wr(1'b0, 8'h00);
        wr(1'b1, 8'h02);
        rd_addr = 1'b1; #1 check("R7 code write ignored", rd_data, 8'h00);

        // R8 restore on exit
        lp_mode = 2'd0;
        rd_addr = 1'b0;
        #1;
        check("R8 pll_en restored", pll_en, 1);
        check("R8 ctrl restored", rd_data, 8'h03);
        tick(1023);
        check("R8 fresh count", locked, 0);
        tick(1);
        check("R8 relocked", locked, 1);
        check("R8 select back", clk_sel_pll, 1);

        // R7 stop mode
        lp_mode = 2'd3;
        tick(5);
        check("R7 stop mode", pll_en, 0);
        lp_mode = 2'd0;
        tick(2);

        // mixed pseudo-random traffic against the model
        r = 32'h1234_5678;
        for (int c = 0; c < 3000; c++) begin
            r ^= r << 13; r ^= r >> 17; r ^= r << 5;
            rd_addr = r[20];
            if (r[15:11] == 5'd0) lp_mode = r[1:0];
            if (r[9:8] == 2'd0) begin
                wr_en = 1'b1;
                wr_addr = r[7];
                wr_data = r[7] ? ((r[25:24] == 2'd0) ? {6'b0, r[1:0]} : 8'h00) : r[31:24];
            end else begin
                wr_en = 1'b0;
            end
            tick(1);
        end
        wr_en = 1'b0;
        tick(2);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule